// File: doc/BRIEF.md
# Tiled-Linear Pixel Blit Engine

This block is a copy engine that moves one image from a source area of memory to a destination area. In one direction it reads an image stored as 8x8 pixel tiles, each tile laid out in Morton (bit-interleaved) order, and writes it out as plain rows. In the other direction it reads plain rows and writes tiles. On the way it can change the pixel format, halve the image by averaging neighbouring source pixels, and mirror the rows vertically. A raw mode moves bytes with no conversion at all.

Configuration is presented on ports and captured by a one-cycle start pulse. The engine then issues one memory read per source sample and one write per output pixel (or per 4-byte chunk in raw mode). When the last write has gone out, the busy flag drops and a one-cycle completion interrupt fires. A configuration the engine cannot handle is refused at the start pulse. The refusal is reported on an error flag, and no memory traffic follows.

Top module: `tile_blit_engine`

## Requirements
- R1: After reset `busy`, `doneIrq`, `cfgError`, `memRdEn` and `memWrEn` are all 0, and no memory access takes place while `busy` is 0.
- R2: Format codes are 0 = 32-bit RGBA8 (R in bits 31:24, A in 7:0), 1 = 24-bit RGB8 (R 23:16, B 7:0), 2 = RGB565 (R 15:11, G 10:5, B 4:0), 3 = RGB5A1 (R 15:11, G 10:6, B 5:1, A bit 0), and 4 = RGBA4 (R 15:12 down to A 3:0). Codes 5 to 7 act as code 2. Pixels are little-endian in memory and use 4, 3 or 2 bytes. Formats without alpha read as alpha 255. Widening a channel to 8 bits repeats its top bits in the freed low bits. Narrowing a channel keeps its top bits.
- R3: With `tiledOut` = 0 the source is read tiled and the destination is written linearly. The source byte offset is (morton(ix,iy) + (iy with bits 2:0 cleared) * `inWidth`) * source bytes. Here morton(x,y) = (x >> 3) * 64 + {y2,x2,y1,x1,y0,x0}. The destination offset is (x + y * outW) * destination bytes.
- R4: With `tiledOut` = 1 the source is read linearly at (x + y * `inWidth`) * source bytes. The destination is written at (morton(x,y) + (y with bits 2:0 cleared) * outW) * destination bytes.
- R5: `scaleMode` = 1 halves the width: outW = `outWidth` >> 1. Each output pixel is the truncated per-channel mean of the source pixel at ix = 2x and the pixel that follows it in memory.
- R6: `scaleMode` = 2 halves both dimensions. Each output pixel is the truncated mean of four consecutive source pixels in memory, starting at (2x, 2y).
- R7: `flipV` = 1 writes output row y at row outH-1-y. The source position is unchanged.
- R8: `rawCopy` = 1 copies outW*outH*destination-bytes bytes unchanged. The copy goes in 4-byte chunks with a shorter last chunk, and no byte past the end is written.
- R9: A start with `scaleMode` = 3, or with `tiledOut` = 1 and a nonzero `scaleMode`, sets `cfgError`, leaves `busy` low, makes no memory access and raises no interrupt. The next accepted start clears `cfgError`.
- R10: After the last write `busy` falls and `doneIrq` pulses for exactly one cycle. A start while `busy` is 1, including the cycle in which `doneIrq` is high, is ignored.
- R11: A start whose output width or height is 0 after scaling completes with `doneIrq` and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle trigger; captures the configuration |
| srcAddr | input | ADDR_W | Source base byte address |
| dstAddr | input | ADDR_W | Destination base byte address |
| inWidth | input | DIM_W | Source row width in pixels |
| outWidth | input | DIM_W | Output width before scaling |
| outHeight | input | DIM_W | Output height before scaling |
| inFmt | input | 3 | Source pixel format code |
| outFmt | input | 3 | Destination pixel format code |
| scaleMode | input | 2 | 0 none, 1 halve width, 2 halve both |
| flipV | input | 1 | Mirror output rows |
| tiledOut | input | 1 | 1: linear to tiled, 0: tiled to linear |
| rawCopy | input | 1 | Byte copy with no conversion |
| memRdEn | output | 1 | Read request |
| memRdAddr | output | ADDR_W | Read byte address |
| memRdData | input | 32 | Four bytes from memRdAddr upward, valid the cycle after the request |
| memWrEn | output | 1 | Write request |
| memWrAddr | output | ADDR_W | Write byte address |
| memWrData | output | 32 | Write bytes, lowest byte to lowest address |
| memWrBytes | output | 3 | Number of bytes to write (1 to 4) |
| busy | output | 1 | Transfer in progress |
| doneIrq | output | 1 | One-cycle completion pulse |
| cfgError | output | 1 | Last start was refused |

## Verification
Two events can fall in the same cycle: the completion pulse and a new start pulse from the host. The bench watches for `doneIrq` and drives `start` high during that very cycle. It then confirms that no further reads or writes appear, that `busy` stays low and that only one interrupt was counted. A second start, given part-way through a transfer, is judged the same way.

// File: rtl/tile_blit_pkg.sv
package tile_blit_pkg;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WAIT, S_WRITE, S_DONE} blitState_e;

  typedef struct packed {
    logic load;
    logic accum;
    logic wrIssue;
  } ctlStrobe_t;

  function automatic logic [2:0] fmtBytes(logic [2:0] f);
    case (f)
      3'd0:    return 3'd4;
      3'd1:    return 3'd3;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [7:0] widen5(logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  // returns {r,g,b,a}
  function automatic logic [31:0] decodePix(logic [2:0] f, logic [31:0] w);
    case (f)
      3'd0:    return w;
      3'd1:    return {w[23:0], 8'hFF};
      3'd3:    return {widen5(w[15:11]), widen5(w[10:6]), widen5(w[5:1]), {8{w[0]}}};
      3'd4:    return {w[15:12], w[15:12], w[11:8], w[11:8], w[7:4], w[7:4], w[3:0], w[3:0]};
      default: return {widen5(w[15:11]), widen6(w[10:5]), widen5(w[4:0]), 8'hFF};
    endcase
  endfunction

  function automatic logic [31:0] encodePix(logic [2:0] f, logic [31:0] c);
    case (f)
      3'd0:    return c;
      3'd1:    return {8'h00, c[31:8]};
      3'd3:    return {16'h0, c[31:27], c[23:19], c[15:11], c[7]};
      3'd4:    return {16'h0, c[31:28], c[23:20], c[15:12], c[7:4]};
      default: return {16'h0, c[31:27], c[23:18], c[15:11]};
    endcase
  endfunction

  // pixel offset of (px,py) inside a row of 8x8 Morton tiles
  function automatic logic [31:0] mortonOff(logic [31:0] px, logic [31:0] py);
    return ((px >> 3) << 6) | {26'd0, py[2], px[2], py[1], px[1], py[0], px[0]};
  endfunction

endpackage

// File: rtl/tile_blit_ctrl.sv
module tile_blit_ctrl
  import tile_blit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       lastSample,
  input  logic       lastUnit,
  input  logic       emptyNow,
  input  logic       rejectNow,
  output ctlStrobe_t ctl,
  output logic       memRdEn,
  output logic       memWrEn,
  output logic       busy,
  output logic       doneIrq,
  output logic       cfgError
);

  blitState_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cfgError <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          if (rejectNow) cfgError <= 1'b1;
          else begin
            cfgError <= 1'b0;
            state    <= emptyNow ? S_DONE : S_READ;
          end
        end
        S_READ:  state <= S_WAIT;
        S_WAIT:  state <= lastSample ? S_WRITE : S_READ;
        S_WRITE: state <= lastUnit ? S_DONE : S_READ;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load    = (state == S_IDLE) && start && !rejectNow;
    ctl.accum   = (state == S_WAIT);
    ctl.wrIssue = (state == S_WRITE);
    memRdEn     = (state == S_READ);
    memWrEn     = (state == S_WRITE);
    busy        = (state != S_IDLE);
    doneIrq     = (state == S_DONE);
  end

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!memRdEn && !memWrEn));

  assert_refused_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && rejectNow) |=> (!busy && cfgError));

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    doneIrq |=> !doneIrq);

  assert_irq_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    doneIrq |=> !busy);

  assert_empty_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !rejectNow && emptyNow) |=> doneIrq);

endmodule

// File: rtl/tile_blit_datapath.sv
module tile_blit_datapath
  import tile_blit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [DIM_W-1:0]  inWidth,
  input  logic [DIM_W-1:0]  outWidth,
  input  logic [DIM_W-1:0]  outHeight,
  input  logic [2:0]        inFmt,
  input  logic [2:0]        outFmt,
  input  logic [1:0]        scaleMode,
  input  logic              flipV,
  input  logic              tiledOut,
  input  logic              rawCopy,
  input  logic [31:0]       memRdData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic [2:0]        memWrBytes,
  output logic              lastSample,
  output logic              lastUnit,
  output logic              emptyNow,
  output logic              rejectNow
);

  localparam int ACC_W = 10;

  logic [31:0]      srcBase, dstBase, rawOff, rawWord;
  logic [DIM_W-1:0] inW, oW, oH, x, y;
  logic [2:0]       inFmtR, outFmtR;
  logic [1:0]       scaleR, k;
  logic             flipR, tiledR, rawR;
  logic [ACC_W-1:0] acc [4];

  // start-time decisions, taken from the ports
  logic hsNow, vsNow;
  assign hsNow     = scaleMode != 2'd0;
  assign vsNow     = scaleMode == 2'd2;
  assign rejectNow = (scaleMode == 2'd3) || (tiledOut && hsNow);
  assign emptyNow  = ((outWidth >> hsNow) == '0) || ((outHeight >> vsNow) == '0);

  // geometry of the current pixel
  logic        hs, vs;
  logic [31:0] bi, bo, xx, inX, inY, yOut, oW32, inW32, srcOff, dstOff, rawTotal, rawLeft;
  logic [31:0] color, sampleCol;
  assign hs    = scaleR != 2'd0;
  assign vs    = scaleR == 2'd2;
  assign bi    = 32'(fmtBytes(inFmtR));
  assign bo    = 32'(fmtBytes(outFmtR));
  assign xx    = 32'(x);
  assign oW32  = 32'(oW);
  assign inW32 = 32'(inW);
  assign inX   = xx << hs;
  assign inY   = 32'(y) << vs;
  assign yOut  = flipR ? (32'(oH) - 32'd1 - 32'(y)) : 32'(y);

  always_comb begin
    if (tiledR) begin
      srcOff = (inX + inY * inW32) * bi;
      dstOff = (mortonOff(xx, yOut) + (yOut & ~32'd7) * oW32) * bo;
    end else begin
      srcOff = (mortonOff(inX, inY) + (inY & ~32'd7) * inW32) * bi;
      dstOff = (xx + yOut * oW32) * bo;
    end
  end

  assign rawTotal = oW32 * 32'(oH) * bo;
  assign rawLeft  = rawTotal - rawOff;

  for (genvar c = 0; c < 4; c++) begin : g_avg
    assign color[31-8*c -: 8] = 8'(acc[c] >> scaleR);
  end

  assign sampleCol  = decodePix(inFmtR, memRdData);
  assign memRdAddr  = ADDR_W'(srcBase + (rawR ? rawOff : srcOff + 32'(k) * bi));
  assign memWrAddr  = ADDR_W'(dstBase + (rawR ? rawOff : dstOff));
  assign memWrData  = rawR ? rawWord : encodePix(outFmtR, color);
  assign memWrBytes = rawR ? ((rawLeft >= 32'd4) ? 3'd4 : rawLeft[2:0]) : bo[2:0];
  assign lastSample = rawR || (k == (vs ? 2'd3 : {1'b0, hs}));
  assign lastUnit   = rawR ? (rawOff + 32'd4 >= rawTotal)
                           : ((x == oW - 1'b1) && (y == oH - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcBase <= '0; dstBase <= '0; rawOff <= '0; rawWord <= '0;
      inW <= '0; oW <= '0; oH <= '0; x <= '0; y <= '0; k <= '0;
      inFmtR <= '0; outFmtR <= '0; scaleR <= '0;
      flipR <= 1'b0; tiledR <= 1'b0; rawR <= 1'b0;
      for (int c = 0; c < 4; c++) acc[c] <= '0;
    end else if (ctl.load) begin
      srcBase <= 32'(srcAddr); dstBase <= 32'(dstAddr);
      inW <= inWidth; oW <= outWidth >> hsNow; oH <= outHeight >> vsNow;
      inFmtR <= inFmt; outFmtR <= outFmt; scaleR <= scaleMode;
      flipR <= flipV; tiledR <= tiledOut; rawR <= rawCopy;
      x <= '0; y <= '0; k <= '0; rawOff <= '0;
      for (int c = 0; c < 4; c++) acc[c] <= '0;
    end else if (ctl.accum) begin
      rawWord <= memRdData;
      k <= k + 2'd1;
      for (int c = 0; c < 4; c++) acc[c] <= acc[c] + ACC_W'(sampleCol[31-8*c -: 8]);
    end else if (ctl.wrIssue) begin
      k <= '0;
      for (int c = 0; c < 4; c++) acc[c] <= '0;
      rawOff <= rawOff + 32'd4;
      if (x == oW - 1'b1) begin
        x <= '0;
        y <= y + 1'b1;
      end else begin
        x <= x + 1'b1;
      end
    end
  end

  assert_chunk_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wrIssue |-> (memWrBytes >= 3'd1 && memWrBytes <= 3'd4));

  assert_pixel_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.wrIssue && !rawR) |-> (x < oW && y < oH));

endmodule

// File: rtl/tile_blit_engine.sv
module tile_blit_engine
  import tile_blit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [DIM_W-1:0]  inWidth,
  input  logic [DIM_W-1:0]  outWidth,
  input  logic [DIM_W-1:0]  outHeight,
  input  logic [2:0]        inFmt,
  input  logic [2:0]        outFmt,
  input  logic [1:0]        scaleMode,
  input  logic              flipV,
  input  logic              tiledOut,
  input  logic              rawCopy,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [31:0]       memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic [2:0]        memWrBytes,
  output logic              busy,
  output logic              doneIrq,
  output logic              cfgError
);

  ctlStrobe_t ctl;
  logic lastSample, lastUnit, emptyNow, rejectNow;

  tile_blit_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .lastSample(lastSample), .lastUnit(lastUnit),
    .emptyNow(emptyNow), .rejectNow(rejectNow),
    .ctl(ctl), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .busy(busy), .doneIrq(doneIrq), .cfgError(cfgError)
  );

  tile_blit_datapath #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .inWidth(inWidth),
    .outWidth(outWidth), .outHeight(outHeight),
    .inFmt(inFmt), .outFmt(outFmt), .scaleMode(scaleMode),
    .flipV(flipV), .tiledOut(tiledOut), .rawCopy(rawCopy),
    .memRdData(memRdData), .memRdAddr(memRdAddr), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memWrBytes(memWrBytes),
    .lastSample(lastSample), .lastUnit(lastUnit),
    .emptyNow(emptyNow), .rejectNow(rejectNow)
  );

endmodule

// File: tb/tile_blit_engine_test.sv
module tile_blit_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cSrc = 32'd0, cDst = 32'd2048;
  logic [9:0]  cInW = '0, cOutW = '0, cOutH = '0;
  logic [2:0]  cInF = '0, cOutF = '0;
  logic [1:0]  cScale = '0;
  logic        cFlip = 1'b0, cTiled = 1'b0, cRaw = 1'b0;

  logic        memRdEn, memWrEn, busy, doneIrq, cfgError;
  logic [31:0] memRdAddr, memWrAddr, memWrData, rdData;
  logic [2:0]  memWrBytes;

  logic [7:0] mem [4096];
  int rdCnt = 0, wrCnt = 0, irqCnt = 0;
  int checks = 0, failures = 0;
  bit sawIrq;

  always #2 clk = ~clk;

  tile_blit_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .srcAddr(cSrc), .dstAddr(cDst), .inWidth(cInW),
    .outWidth(cOutW), .outHeight(cOutH), .inFmt(cInF), .outFmt(cOutF),
    .scaleMode(cScale), .flipV(cFlip), .tiledOut(cTiled), .rawCopy(cRaw),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(rdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrBytes(memWrBytes), .busy(busy), .doneIrq(doneIrq), .cfgError(cfgError)
  );

  always @(posedge clk) begin
    if (memRdEn) begin
      rdData <= {mem[(memRdAddr+3) & 4095], mem[(memRdAddr+2) & 4095],
                 mem[(memRdAddr+1) & 4095], mem[memRdAddr & 4095]};
      rdCnt <= rdCnt + 1;
    end
    if (memWrEn) begin
      for (int i = 0; i < 4; i++)
        if (i < int'(memWrBytes)) mem[(memWrAddr + i) & 4095] <= memWrData[8*i +: 8];
      wrCnt <= wrCnt + 1;
    end
    if (doneIrq) irqCnt <= irqCnt + 1;
  end

  initial begin
    #2000000;
    failures++; checks++;
    $display("FAIL watchdog: run did not end (actual hung, expected finish)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------- bench reference model ----------
  function automatic int bBytes(int f);
    return (f == 0) ? 4 : (f == 1) ? 3 : 2;
  endfunction

  function automatic int rep(int v, int bits);
    return (v << (8 - bits)) | (v >> (2 * bits - 8));
  endfunction

  // channel array: 0 r, 1 g, 2 b, 3 a
  task automatic bDec(int f, int w, output int ch [4]);
    case (f)
      0: begin ch[0] = (w >> 24) & 255; ch[1] = (w >> 16) & 255; ch[2] = (w >> 8) & 255; ch[3] = w & 255; end
      1: begin ch[0] = (w >> 16) & 255; ch[1] = (w >> 8) & 255; ch[2] = w & 255; ch[3] = 255; end
      3: begin ch[0] = rep((w >> 11) & 31, 5); ch[1] = rep((w >> 6) & 31, 5);
               ch[2] = rep((w >> 1) & 31, 5); ch[3] = (w & 1) ? 255 : 0; end
      4: begin ch[0] = ((w >> 12) & 15) * 17; ch[1] = ((w >> 8) & 15) * 17;
               ch[2] = ((w >> 4) & 15) * 17; ch[3] = (w & 15) * 17; end
      default: begin ch[0] = rep((w >> 11) & 31, 5); ch[1] = rep((w >> 5) & 63, 6);
               ch[2] = rep(w & 31, 5); ch[3] = 255; end
    endcase
  endtask

  function automatic int bEnc(int f, int ch [4]);
    case (f)
      0: return (ch[0] << 24) | (ch[1] << 16) | (ch[2] << 8) | ch[3];
      1: return (ch[0] << 16) | (ch[1] << 8) | ch[2];
      3: return ((ch[0] >> 3) << 11) | ((ch[1] >> 3) << 6) | ((ch[2] >> 3) << 1) | (ch[3] >> 7);
      4: return ((ch[0] >> 4) << 12) | ((ch[1] >> 4) << 8) | ((ch[2] >> 4) << 4) | (ch[3] >> 4);
      default: return ((ch[0] >> 3) << 11) | ((ch[1] >> 2) << 5) | (ch[2] >> 3);
    endcase
  endfunction

  function automatic int bMorton(int px, int py);
    int r = (px / 8) * 64;
    for (int b = 0; b < 3; b++) begin
      r += ((px >> b) & 1) << (2 * b);
      r += ((py >> b) & 1) << (2 * b + 1);
    end
    return r;
  endfunction

  function automatic int rdBytes(int addr, int n);
    int v = 0;
    for (int i = 0; i < n; i++) v |= int'(mem[(addr + i) & 4095]) << (8 * i);
    return v;
  endfunction

  task automatic checkImage(string req, string what);
    int hs = (cScale != 0), vs = (cScale == 2), n = (cScale == 2) ? 4 : (cScale == 1) ? 2 : 1;
    int oW = int'(cOutW) >> hs, oH = int'(cOutH) >> vs;
    int bi = bBytes(int'(cInF)), bo = bBytes(int'(cOutF));
    int bad = 0, firstAct = 0, firstExp = 0;
    for (int y = 0; y < oH; y++) begin
      for (int x = 0; x < oW; x++) begin
        int ix = x << hs, iy = y << vs, yo = cFlip ? oH - 1 - y : y;
        int so, dof, exp, act;
        int sum [4];
        int ch [4];
        if (cTiled) begin
          so  = (ix + iy * int'(cInW)) * bi;
          dof = (bMorton(x, yo) + (yo & ~7) * oW) * bo;
        end else begin
          so  = (bMorton(ix, iy) + (iy & ~7) * int'(cInW)) * bi;
          dof = (x + yo * oW) * bo;
        end
        for (int c = 0; c < 4; c++) sum[c] = 0;
        for (int s = 0; s < n; s++) begin
          bDec(int'(cInF), rdBytes(int'(cSrc) + so + s * bi, bi), ch);
          for (int c = 0; c < 4; c++) sum[c] += ch[c];
        end
        for (int c = 0; c < 4; c++) ch[c] = sum[c] / n;
        exp = bEnc(int'(cOutF), ch);
        act = rdBytes(int'(cDst) + dof, bo);
        if (act != exp) begin
          if (bad == 0) begin firstAct = act; firstExp = exp; end
          bad++;
        end
      end
    end
    check(bad == 0, req, what, firstAct, firstExp);
    check(wrCnt == oW * oH, req, {what, " write count"}, wrCnt, oW * oH);
  endtask

  task automatic fillMem(int seed);
    for (int i = 0; i < 2048; i++) mem[i] = 8'((i * seed + (i >> 5) * 13 + 5) & 255);
    for (int i = 2048; i < 4096; i++) mem[i] = 8'hEE;
  endtask

  task automatic setCfg(int inW, int oW, int oH, int fi, int fo, int sc, bit fl, bit ti, bit rw);
    cInW = 10'(inW); cOutW = 10'(oW); cOutH = 10'(oH);
    cInF = 3'(fi); cOutF = 3'(fo); cScale = 2'(sc);
    cFlip = fl; cTiled = ti; cRaw = rw;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic runJob();
    rdCnt = 0; wrCnt = 0; irqCnt = 0; sawIrq = 0;
    pulseStart();
    for (int i = 0; i < 20000 && !sawIrq; i++) begin
      if (doneIrq) sawIrq = 1;
      else @(negedge clk);
    end
    @(negedge clk);
  endtask

  // ---------- scenarios ----------
  task automatic t_reset();
    check(busy == 0 && doneIrq == 0, "R1", "busy/irq after reset", {busy, doneIrq}, 0);
    check(cfgError == 0, "R1", "cfgError after reset", cfgError, 0);
    check(memRdEn == 0 && memWrEn == 0, "R1", "memory idle after reset", {memRdEn, memWrEn}, 0);
  endtask

  task automatic t_detile();
    fillMem(37);
    setCfg(16, 16, 8, 0, 2, 0, 0, 0, 0);
    runJob();
    check(sawIrq, "R10", "detile completion irq", sawIrq, 1);
    checkImage("R3", "tiled RGBA8 to linear RGB565 (R2 narrowing)");
    check(busy == 0 && irqCnt == 1, "R10", "busy low, one irq", irqCnt, 1);
  endtask

  task automatic t_tileOut();
    fillMem(53);
    setCfg(16, 16, 8, 1, 0, 0, 0, 1, 0);
    runJob();
    checkImage("R4", "linear RGB8 to tiled RGBA8 (R2 alpha 255)");
  endtask

  task automatic t_halveX();
    fillMem(29);
    setCfg(16, 16, 8, 4, 0, 1, 0, 0, 0);
    runJob();
    checkImage("R5", "halve width RGBA4 to RGBA8 (R2 widening)");
    check(rdCnt == 128, "R5", "two reads per pixel", rdCnt, 128);
  endtask

  task automatic t_halveXY();
    fillMem(71);
    setCfg(16, 16, 16, 3, 0, 2, 0, 0, 0);
    runJob();
    checkImage("R6", "halve both RGB5A1 to RGBA8");
    check(rdCnt == 256, "R6", "four reads per pixel", rdCnt, 256);
  endtask

  task automatic t_flip();
    fillMem(19);
    setCfg(8, 8, 16, 0, 0, 0, 1, 0, 0);
    runJob();
    checkImage("R7", "vertical flip tiled to linear");
    fillMem(23);
    setCfg(8, 8, 16, 2, 1, 0, 1, 1, 0);
    runJob();
    checkImage("R7", "vertical flip linear to tiled");
  endtask

  task automatic t_raw();
    int bad = 0;
    fillMem(41);
    setCfg(0, 5, 1, 0, 2, 0, 0, 0, 1);
    runJob();
    for (int i = 0; i < 10; i++) if (mem[2048 + i] != mem[i]) bad++;
    check(bad == 0, "R8", "raw bytes copied unchanged", bad, 0);
    check(mem[2058] == 8'hEE, "R8", "byte past raw end untouched", mem[2058], 8'hEE);
    check(wrCnt == 3 && rdCnt == 3, "R8", "raw chunk count", wrCnt, 3);
  endtask

  task automatic t_reject();
    fillMem(11);
    setCfg(16, 16, 8, 0, 0, 3, 0, 0, 0);
    runJob();
    check(cfgError == 1 && busy == 0, "R9", "scale code 3 refused", {cfgError, busy}, 2);
    check(rdCnt == 0 && wrCnt == 0 && irqCnt == 0, "R9", "no activity on scale 3", rdCnt + wrCnt + irqCnt, 0);
    setCfg(16, 16, 8, 0, 0, 1, 0, 1, 0);
    runJob();
    check(cfgError == 1 && rdCnt + wrCnt + irqCnt == 0, "R9", "scaled tiled output refused",
          rdCnt + wrCnt + irqCnt, 0);
    setCfg(8, 8, 8, 0, 0, 0, 0, 0, 0);
    runJob();
    check(cfgError == 0 && sawIrq, "R9", "accepted start clears error", cfgError, 0);
  endtask

  task automatic t_empty();
    setCfg(8, 1, 8, 0, 0, 1, 0, 0, 0);
    runJob();
    check(sawIrq, "R11", "empty job completes", sawIrq, 1);
    check(rdCnt == 0 && wrCnt == 0, "R11", "empty job no memory access", rdCnt + wrCnt, 0);
  endtask

  task automatic t_startCollide();
    int rdMark;
    fillMem(61);
    setCfg(8, 8, 8, 0, 0, 0, 0, 0, 0);
    rdCnt = 0; wrCnt = 0; irqCnt = 0;
    pulseStart();
    repeat (5) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int i = 0; i < 20000 && !doneIrq; i++) @(negedge clk);
    start = 1'b1;                     // start in the irq cycle
    @(negedge clk); start = 1'b0;
    rdMark = rdCnt;
    repeat (10) @(negedge clk);
    check(busy == 0, "R10", "start in irq cycle ignored (busy)", busy, 0);
    check(rdCnt == rdMark && wrCnt == 64, "R10", "no extra traffic after collisions", wrCnt, 64);
    check(irqCnt == 1, "R10", "single irq despite extra starts", irqCnt, 1);
    checkImage("R10", "image intact after busy start");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_detile();
    t_tileOut();
    t_halveX();
    t_halveXY();
    t_flip();
    t_raw();
    t_reject();
    t_empty();
    t_startCollide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule